// File: doc/BRIEF.md
# Protected Mode Register and Area Decoder

This block holds an 8-bit processor-mode control register on a single-cycle select/write-enable bus, together with the logic that the register steers. Software can change the register only while an external protect-enable input is high. One bit chooses how the watchdog responds. Once software sets it, no write can clear it. While a flash rewrite-mode input is high, two bits read as 1, and they return to their stored values when that input drops.

The effective register value sets the memory map. Each 20-bit access address is placed in exactly one class: internal RAM, internal ROM, reserved, the CS2 window, or external. When the wait bit is set, a request to internal RAM or ROM pulls ready low for one cycle. The requester keeps its request and address stable until ready is high again.

Top module: `pmode_ctl`

## Requirements
- R1: After reset the register reads 08h, `wdt_rst_o` is 0 and `port_fn_o` is 0.
- R2: A write (`sel_i`=1, `we_i`=1) changes the register only if `prot_wen_i` is 1 in the same cycle. If `prot_wen_i` is 0, the register keeps its old value.
- R3: Bit 2 (watchdog select, shown on `wdt_rst_o`) is set-only. Writing 1 sets it. Writing 0 leaves it unchanged until reset.
- R4: Bits 6 to 4 always read as 0, whatever was written to them.
- R5: While `flash_rw_i` is 1, bits 0 and 3 read as 1 and the map uses them as 1. When `flash_rw_i` returns to 0, the stored values apply again.
- R6: 00400h to 03FFFh is internal RAM. 04000h to 07FFFh is internal RAM when bit 3 is 1 and reserved when bit 3 is 0.
- R7: D0000h to FFFFFh is internal ROM. 80000h to CFFFFh is internal ROM when bit 3 is 1 and reserved when bit 3 is 0.
- R8: With bit 0 = 0, the CS2 window is 08000h to 26FFFh. With bit 0 = 1, the CS2 window is 10000h to 26FFFh and 0F000h to 0FFFFh is internal ROM.
- R9: An address outside every range above is external. Exactly one of the five class flags is high at all times.
- R10: If bit 7 is 1 and a request hits internal RAM or ROM while ready is high, ready is low for exactly the next cycle and then high. Requests with bit 7 = 0, and requests to other classes, leave ready high.
- R11: A request held high across consecutive wait-state accesses produces ready low every other cycle. Ready is never low for two cycles in a row.
- R12: `rdata_o` carries the effective register value when `sel_i`=1 and `we_i`=0, and 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable (read when 0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| prot_wen_i | input | 1 | Protect-enable, 1 permits writes |
| flash_rw_i | input | 1 | Flash rewrite mode, forces bits 0 and 3 |
| req_i | input | 1 | Access request |
| addr_i | input | 20 | Access address |
| ready_o | output | 1 | Access ready, low during a wait state |
| is_ram_o | output | 1 | Address is internal RAM |
| is_rom_o | output | 1 | Address is internal ROM |
| is_rsvd_o | output | 1 | Address is reserved |
| is_cs2_o | output | 1 | Address is in the CS2 window |
| is_ext_o | output | 1 | Address is external |
| wdt_rst_o | output | 1 | Watchdog select: 1 means reset, 0 means interrupt |
| port_fn_o | output | 1 | Bit 1: pins act as port instead of address |

## Verification
The hardest states to reach are the ones where stored and effective values differ: the sticky bit after a later clearing write, and the forced bits while rewrite mode is active. The stimulus first clears the register through a protected write. It then raises `flash_rw_i` and checks both the read value and the reclassification of 0F000h and 05000h. After dropping the input, it checks that the stored zeros return. Back-to-back wait states are reached by holding `req_i` high on a RAM address for four cycles with bit 7 set. The expected ready pattern is checked in each of those cycles.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_BLKA   = 0;
  localparam int unsigned B_PORT   = 1;
  localparam int unsigned B_WDT    = 2;
  localparam int unsigned B_EXT    = 3;
  localparam int unsigned B_WAIT   = 7;

  localparam logic [REG_W-1:0] RESET_VAL   = 8'h08;
  localparam logic [REG_W-1:0] WR_MASK     = 8'h8F;
  localparam logic [REG_W-1:0] STICKY_MASK = 8'h04;
  localparam logic [REG_W-1:0] FORCE_MASK  = 8'h09;

  typedef struct packed {
    logic wait_en;
    logic area_ext;
    logic wdt_rst;
    logic port_fn;
    logic blka_en;
  } mode_t;

  typedef struct packed {
    logic ram;
    logic rom;
    logic rsvd;
    logic cs2;
    logic ext;
  } area_t;
endpackage

// File: rtl/pmode_reg.sv
module pmode_reg
  import pmode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             prot_wen_i,
  input  logic             flash_rw_i,
  output logic [REG_W-1:0] reg_q_o,
  output mode_t            mode_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] reg_q, wr_val, eff;
  logic wr;

  assign wr     = sel_i & we_i & prot_wen_i;
  // sticky bit ORs with its old value; reserved bits drop out
  assign wr_val = (wdata_i & WR_MASK) | (reg_q & STICKY_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  reg_q <= RESET_VAL;
    else if (wr)  reg_q <= wr_val;
  end

  assign eff = reg_q | (flash_rw_i ? FORCE_MASK : '0);

  assign mode_o.wait_en  = eff[B_WAIT];
  assign mode_o.area_ext = eff[B_EXT];
  assign mode_o.wdt_rst  = eff[B_WDT];
  assign mode_o.port_fn  = eff[B_PORT];
  assign mode_o.blka_en  = eff[B_BLKA];

  assign rdata_o = (sel_i & ~we_i) ? eff : '0;
  assign reg_q_o = reg_q;
endmodule

// File: rtl/pmode_decode.sv
module pmode_decode
  import pmode_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RAM_LO   = 'h00400,
  parameter logic [ADDR_W-1:0] RAM_HI   = 'h03FFF,
  parameter logic [ADDR_W-1:0] RAMX_LO  = 'h04000,
  parameter logic [ADDR_W-1:0] RAMX_HI  = 'h07FFF,
  parameter logic [ADDR_W-1:0] BLKA_LO  = 'h0F000,
  parameter logic [ADDR_W-1:0] BLKA_HI  = 'h0FFFF,
  parameter logic [ADDR_W-1:0] CS2_LO0  = 'h08000,
  parameter logic [ADDR_W-1:0] CS2_LO1  = 'h10000,
  parameter logic [ADDR_W-1:0] CS2_HI   = 'h26FFF,
  parameter logic [ADDR_W-1:0] ROMX_LO  = 'h80000,
  parameter logic [ADDR_W-1:0] ROMX_HI  = 'hCFFFF,
  parameter logic [ADDR_W-1:0] ROM_LO   = 'hD0000,
  parameter logic [ADDR_W-1:0] ROM_HI   = 'hFFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  mode_t             mode_i,
  output area_t             area_o
);
  function automatic logic in_rng(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [ADDR_W-1:0] cs2_lo;
  assign cs2_lo = mode_i.blka_en ? CS2_LO1 : CS2_LO0;

  always_comb begin
    area_o = '0;
    if (in_rng(addr_i, RAM_LO, RAM_HI))
      area_o.ram = 1'b1;
    else if (in_rng(addr_i, RAMX_LO, RAMX_HI)) begin
      if (mode_i.area_ext) area_o.ram  = 1'b1;
      else                 area_o.rsvd = 1'b1;
    end
    else if (mode_i.blka_en && in_rng(addr_i, BLKA_LO, BLKA_HI))
      area_o.rom = 1'b1;
    else if (in_rng(addr_i, cs2_lo, CS2_HI))
      area_o.cs2 = 1'b1;
    else if (in_rng(addr_i, ROM_LO, ROM_HI))
      area_o.rom = 1'b1;
    else if (in_rng(addr_i, ROMX_LO, ROMX_HI)) begin
      if (mode_i.area_ext) area_o.rom  = 1'b1;
      else                 area_o.rsvd = 1'b1;
    end
    else
      area_o.ext = 1'b1;
  end
endmodule

// File: rtl/pmode_wait.sv
module pmode_wait (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic need_wait_i,
  output logic ready_o
);
  logic pend_q;

  // a request seen while ready is low is the held one, not a new one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= req_i & need_wait_i & ~pend_q;
  end

  assign ready_o = ~pend_q;
endmodule

// File: rtl/pmode_ctl.sv
module pmode_ctl
  import pmode_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              prot_wen_i,
  input  logic              flash_rw_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              is_ram_o,
  output logic              is_rom_o,
  output logic              is_rsvd_o,
  output logic              is_cs2_o,
  output logic              is_ext_o,
  output logic              wdt_rst_o,
  output logic              port_fn_o
);
  logic [REG_W-1:0] reg_q;
  mode_t mode;
  area_t area;

  pmode_reg u_reg (
    .clk_i, .rst_ni, .sel_i, .we_i, .wdata_i, .prot_wen_i, .flash_rw_i,
    .reg_q_o(reg_q), .mode_o(mode), .rdata_o(rdata_o)
  );

  pmode_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i, .mode_i(mode), .area_o(area)
  );

  pmode_wait u_wait (
    .clk_i, .rst_ni, .req_i,
    .need_wait_i(mode.wait_en & (area.ram | area.rom)),
    .ready_o(ready_o)
  );

  assign is_ram_o  = area.ram;
  assign is_rom_o  = area.rom;
  assign is_rsvd_o = area.rsvd;
  assign is_cs2_o  = area.cs2;
  assign is_ext_o  = area.ext;
  assign wdt_rst_o = mode.wdt_rst;
  assign port_fn_o = mode.port_fn;
endmodule

// File: rtl/pmode_chk.sv
module pmode_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic              prot_wen_i,
  input logic              flash_rw_i,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        reg_q,
  input logic              ready_o,
  input logic              is_ram_o,
  input logic              is_rom_o,
  input logic              is_rsvd_o,
  input logic              is_cs2_o,
  input logic              is_ext_o,
  input logic              wdt_rst_o
);
  assert_prot_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !prot_wen_i) |=> (reg_q == $past(reg_q)));

  assert_wdt_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> wdt_rst_o);

  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6:4] == 3'b000);

  assert_flash_blka_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_rw_i && addr_i[19:12] == 8'h0F) |-> is_rom_o);

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({is_ram_o, is_rom_o, is_rsvd_o, is_cs2_o, is_ext_o}) == 1);

  assert_wait_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && reg_q[7] && !flash_rw_i && (is_ram_o || is_rom_o)) |=> !ready_o);

  assert_ready_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);
endmodule

bind pmode_ctl pmode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
  .prot_wen_i(prot_wen_i), .flash_rw_i(flash_rw_i), .req_i(req_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .reg_q(reg_q), .ready_o(ready_o),
  .is_ram_o(is_ram_o), .is_rom_o(is_rom_o), .is_rsvd_o(is_rsvd_o),
  .is_cs2_o(is_cs2_o), .is_ext_o(is_ext_o), .wdt_rst_o(wdt_rst_o)
);

// File: tb/sim_pmode_ctl.sv
`timescale 1ns/100ps
module sim_pmode_ctl;
  localparam int K_RD = 0, K_AREA = 1, K_RDY = 2, K_MODE = 3;
  // area encoding {ram,rom,rsvd,cs2,ext}
  localparam logic [7:0] A_RAM = 8'h10, A_ROM = 8'h08, A_RSV = 8'h04,
                         A_CS2 = 8'h02, A_EXT = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, we = 0, prot = 0, flash = 0, req = 0;
  logic [7:0] wdata = '0;
  logic [19:0] addr = '0;
  logic [7:0] rdata;
  logic ready, is_ram, is_rom, is_rsvd, is_cs2, is_ext, wdt_rst, port_fn;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;
  logic [7:0] act;

  always #2.5 clk = ~clk;

  pmode_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .prot_wen_i(prot), .flash_rw_i(flash), .req_i(req),
    .addr_i(addr), .ready_o(ready), .is_ram_o(is_ram), .is_rom_o(is_rom),
    .is_rsvd_o(is_rsvd), .is_cs2_o(is_cs2), .is_ext_o(is_ext),
    .wdt_rst_o(wdt_rst), .port_fn_o(port_fn)
  );

  // monitor: compare queued expectations against outputs mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = rdata;
        K_AREA:  act = {3'b000, is_ram, is_rom, is_rsvd, is_cs2, is_ext};
        K_RDY:   act = {7'b0, ready};
        default: act = {6'b0, wdt_rst, port_fn};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t e;
    e.kind = kind; e.exp = exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d, input logic p);
    sel = 1; we = 1; wdata = d; prot = p;
    @(posedge clk); #1;
    sel = 0; we = 0; prot = 0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    sel = 1; we = 0;
    push(K_RD, exp, tag);
    step();
    sel = 0;
  endtask

  task automatic area(input logic [19:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    push(K_AREA, exp, tag);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    rd(8'h08, "R1 reset value");
    push(K_MODE, 8'h00, "R1 reset wdt/port"); step();
    push(K_RD, 8'h00, "R12 unselected read"); step();

    area(20'h00500, A_RAM, "R6 base RAM");
    area(20'h05000, A_RAM, "R6 expansion RAM b3=1");
    area(20'h90000, A_ROM, "R7 expansion ROM b3=1");
    area(20'hE0000, A_ROM, "R7 base ROM");
    area(20'h0F800, A_CS2, "R8 0F800 in CS2 b0=0");
    area(20'h09000, A_CS2, "R8 09000 in CS2 b0=0");
    area(20'h00100, A_EXT, "R9 low external");
    area(20'h27000, A_EXT, "R9 above CS2");
    area(20'h30000, A_EXT, "R9 mid external");

    wr(8'hFF, 1'b0);
    rd(8'h08, "R2 write ignored without protect enable");
    push(K_MODE, 8'h00, "R2 outputs unchanged"); step();

    wr(8'h00, 1'b1);
    rd(8'h00, "R2 protected write");
    area(20'h05000, A_RSV, "R6 expansion reserved b3=0");
    area(20'h04000, A_RSV, "R6 04000 reserved");
    area(20'h07FFF, A_RSV, "R6 07FFF reserved");
    area(20'h03FFF, A_RAM, "R6 03FFF RAM");
    area(20'h80000, A_RSV, "R7 80000 reserved");
    area(20'hCFFFF, A_RSV, "R7 CFFFF reserved");
    area(20'hD0000, A_ROM, "R7 D0000 ROM");
    area(20'h08000, A_CS2, "R8 08000 CS2 start");

    wr(8'h01, 1'b1);
    area(20'h0F000, A_ROM, "R8 block A start");
    area(20'h0FFFF, A_ROM, "R8 block A end");
    area(20'h09000, A_EXT, "R8 09000 outside CS2 b0=1");
    area(20'h10000, A_CS2, "R8 CS2 start b0=1");
    area(20'h26FFF, A_CS2, "R8 CS2 end");

    wr(8'h00, 1'b1);
    flash = 1;
    rd(8'h09, "R5 forced bits read");
    area(20'h0F800, A_ROM, "R5 forced block A");
    area(20'h05000, A_RAM, "R5 forced expansion");
    flash = 0;
    rd(8'h00, "R5 stored bits restored");
    area(20'h05000, A_RSV, "R5 map restored");

    wr(8'hF6, 1'b1);
    rd(8'h86, "R4 reserved bits read zero");
    push(K_MODE, 8'h03, "R3 set by write"); step();
    wr(8'h00, 1'b1);
    rd(8'h04, "R3 clear attempt ignored");
    push(K_MODE, 8'h02, "R3 still set"); step();
    sel = 1; we = 1; prot = 0;
    push(K_RD, 8'h00, "R12 read zero during write"); step();
    sel = 0; we = 0;

    // wait states, b7=1 b3=1
    wr(8'h88, 1'b1);
    req = 1; addr = 20'h00500;
    push(K_RDY, 8'h01, "R10 ready at request"); step();
    req = 0;
    push(K_RDY, 8'h00, "R10 wait cycle"); step();
    push(K_RDY, 8'h01, "R10 ready returns"); step();

    req = 1;
    push(K_RDY, 8'h01, "R11 b2b first"); step();
    push(K_RDY, 8'h00, "R11 b2b wait 1"); step();
    push(K_RDY, 8'h01, "R11 b2b second"); step();
    push(K_RDY, 8'h00, "R11 b2b wait 2"); step();
    req = 0;
    push(K_RDY, 8'h01, "R11 b2b done"); step();

    req = 1; addr = 20'h30000;
    push(K_RDY, 8'h01, "R10 external no wait a"); step();
    push(K_RDY, 8'h01, "R10 external no wait b"); step();
    req = 0;

    wr(8'h08, 1'b1);
    req = 1; addr = 20'h00500;
    push(K_RDY, 8'h01, "R10 b7=0 no wait a"); step();
    push(K_RDY, 8'h01, "R10 b7=0 no wait b"); step();
    req = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule